// File: doc/BRIEF.md
# Return Address Stack with Sticky Status

This block is a hardware last-in-first-out store for 24-bit return addresses. A sequencer pushes an address when it enters a subroutine, takes an interrupt or starts a hardware loop, and pops it again on the matching return or loop exit. The current top entry is always visible on an output, together with a pointer that counts the entries in use.

Status is kept two ways. Live full and empty flags follow the stack level. Four sticky bits record four events:
- the stack was seen full;
- the stack was seen empty;
- a push was refused (overflow);
- a pop was refused (underflow).

Sticky bits stay set until an explicit clear strobe. A stack-full interrupt request comes from the sticky full bit and can be masked. A separate high-water request is raised one entry early, at 29 of 30. This leaves room for the interrupt's own push to land in the last slot before the full request follows.

Top module: `pc_ret_stack`

## Requirements
- R1: The stack holds 30 entries of 24 bits. After reset the pointer reads 0, empty is 1, full is 0, and all sticky bits and both interrupt requests are 0.
- R2: A push alone on a stack that is not full stores the address in the next free slot. In the following cycle the pointer is one higher and the top output shows the pushed address.
- R3: A push alone on a full stack (pointer 30) changes neither the pointer nor the contents, and sets the sticky overflow bit.
- R4: A pop alone on a non-empty stack lowers the pointer by one. The top output then shows the entry pushed before the removed one (last in, first out).
- R5: A pop alone on an empty stack changes nothing and sets the sticky underflow bit.
- R6: Push and pop together on a non-empty stack replace the top entry with the pushed address and leave the pointer unchanged. Push and pop together on an empty stack change nothing and set the sticky underflow bit.
- R7: The live full output is 1 exactly when the pointer is 30. The live empty output is 1 exactly when the pointer is 0.
- R8: Each sticky bit (full seen, empty seen, overflow, underflow) is set in the cycle after its condition or event and stays set until the clear strobe. The clear strobe drops a bit only if its condition or event is absent in that same cycle; otherwise the bit stays 1.
- R9: The stack-full interrupt request equals the sticky full bit while the mask input is 0, and is 0 while the mask input is 1.
- R10: The high-water interrupt request is 1 exactly when the pointer is 29.
- R11: The top output reads 0 while the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_addr_i | input | 24 | Address to push |
| mask_full_i | input | 1 | 1 masks the stack-full interrupt request |
| clr_sticky_i | input | 1 | Strobe clearing all sticky bits |
| top_o | output | 24 | Top entry, 0 when empty |
| ptr_o | output | 5 | Number of entries in use |
| full_o | output | 1 | Live full flag |
| empty_o | output | 1 | Live empty flag |
| hwm_irq_o | output | 1 | High-water request at one entry below full |
| sticky_full_o | output | 1 | Sticky: stack was full |
| sticky_empty_o | output | 1 | Sticky: stack was empty |
| sticky_ovf_o | output | 1 | Sticky: push refused |
| sticky_unf_o | output | 1 | Sticky: pop refused |
| full_irq_o | output | 1 | Maskable stack-full interrupt request |

## Verification
The hardest states to reach from the ports sit at the top of the stack. These are the 29-entry high-water point, the full stack, and overflow or replacement while full; evenly mixed random operations almost never climb that far. The stimulus therefore runs phases with a strong push bias that drive the level up to 30 and hold it there. Directed sequences add a clear strobe issued while the full condition persists, and a combined push and pop on an empty stack.

// File: rtl/pc_ret_stack_pkg.sv
package pc_ret_stack_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  // Level after an accepted operation.
  function automatic int unsigned lvl_next(int unsigned lvl, stk_op_e op);
    case (op)
      OP_PUSH: return lvl + 1;
      OP_POP:  return lvl - 1;
      default: return lvl;
    endcase
  endfunction

  // Sticky bit update: the clear acts first, then a present condition sets it.
  function automatic logic sticky_next(logic cur, logic clr, logic cond);
    return (cur & ~clr) | cond;
  endfunction

endpackage

// File: rtl/pc_ret_stack_ctrl.sv
module pc_ret_stack_ctrl
  import pc_ret_stack_pkg::*;
#(
  parameter int DEPTH = 30,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] level_i,
  output stk_op_e       op_o,
  output logic          ovf_evt_o,
  output logic          unf_evt_o
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

  logic is_full;
  logic is_empty;

  assign is_full  = (level_i == LVL_FULL);
  assign is_empty = (level_i == '0);

  always_comb begin
    op_o      = OP_IDLE;
    ovf_evt_o = 1'b0;
    unf_evt_o = 1'b0;
    if (push_i && pop_i) begin
      if (is_empty) unf_evt_o = 1'b1;
      else          op_o      = OP_SWAP;
    end else if (push_i) begin
      if (is_full) ovf_evt_o = 1'b1;
      else         op_o      = OP_PUSH;
    end else if (pop_i) begin
      if (is_empty) unf_evt_o = 1'b1;
      else          op_o      = OP_POP;
    end
  end
endmodule

// File: rtl/pc_ret_stack_store.sv
module pc_ret_stack_store
  import pc_ret_stack_pkg::*;
#(
  parameter int DEPTH = 30,
  parameter int AW    = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [CW-1:0] level_o,
  output logic [AW-1:0] top_o
);
  logic [CW-1:0] level_q;
  logic [CW-1:0] level_d;
  logic [CW-1:0] wr_idx;
  logic          wr_en;
  logic [AW-1:0] slot_q [DEPTH];

  assign level_d = CW'(lvl_next(int'(level_q), op_i));
  assign wr_en   = (op_i == OP_PUSH) || (op_i == OP_SWAP);
  assign wr_idx  = (op_i == OP_PUSH) ? level_q : (level_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[g] <= '0;
      else if (wr_en && wr_idx == CW'(g))   slot_q[g] <= wr_data_i;
    end
  end

  assign level_o = level_q;
  assign top_o   = (level_q == '0) ? '0 : slot_q[level_q - 1'b1];
endmodule

// File: rtl/pc_ret_stack_status.sv
module pc_ret_stack_status
  import pc_ret_stack_pkg::*;
#(
  parameter int DEPTH = 30,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] level_i,
  input  logic          ovf_evt_i,
  input  logic          unf_evt_i,
  input  logic          clr_i,
  input  logic          mask_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          hwm_o,
  output logic          st_full_o,
  output logic          st_empty_o,
  output logic          st_ovf_o,
  output logic          st_unf_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HWM  = CW'(DEPTH - 1);

  logic [3:0] st_q;
  logic [3:0] cond;

  assign full_o  = (level_i == LVL_FULL);
  assign empty_o = (level_i == '0);
  assign hwm_o   = (level_i == LVL_HWM);
  assign cond    = {unf_evt_i, ovf_evt_i, empty_o, full_o};

  for (genvar g = 0; g < 4; g++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= 1'b0;
      else         st_q[g] <= sticky_next(st_q[g], clr_i, cond[g]);
    end
  end

  assign st_full_o  = st_q[0];
  assign st_empty_o = st_q[1];
  assign st_ovf_o   = st_q[2];
  assign st_unf_o   = st_q[3];
  assign irq_o      = st_q[0] & ~mask_i;
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack
  import pc_ret_stack_pkg::*;
#(
  parameter int DEPTH = 30,
  parameter int AW    = 24,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          mask_full_i,
  input  logic          clr_sticky_i,
  output logic [AW-1:0] top_o,
  output logic [CW-1:0] ptr_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          hwm_irq_o,
  output logic          sticky_full_o,
  output logic          sticky_empty_o,
  output logic          sticky_ovf_o,
  output logic          sticky_unf_o,
  output logic          full_irq_o
);
  // Named internal events, visible to the bound checker.
  stk_op_e       op;
  logic          ovf_evt;
  logic          unf_evt;
  logic [CW-1:0] level;

  pc_ret_stack_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .push_i    (push_i),
    .pop_i     (pop_i),
    .level_i   (level),
    .op_o      (op),
    .ovf_evt_o (ovf_evt),
    .unf_evt_o (unf_evt)
  );

  pc_ret_stack_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wr_data_i (push_addr_i),
    .level_o   (level),
    .top_o     (top_o)
  );

  pc_ret_stack_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .ovf_evt_i  (ovf_evt),
    .unf_evt_i  (unf_evt),
    .clr_i      (clr_sticky_i),
    .mask_i     (mask_full_i),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .hwm_o      (hwm_irq_o),
    .st_full_o  (sticky_full_o),
    .st_empty_o (sticky_empty_o),
    .st_ovf_o   (sticky_ovf_o),
    .st_unf_o   (sticky_unf_o),
    .irq_o      (full_irq_o)
  );

  assign ptr_o = level;
endmodule

// File: rtl/pc_ret_stack_chk.sv
module pc_ret_stack_chk #(
  parameter int DEPTH = 30,
  parameter int AW    = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic          mask_full_i,
  input logic [AW-1:0] top_o,
  input logic [CW-1:0] ptr_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          hwm_irq_o,
  input logic          sticky_full_o,
  input logic          sticky_ovf_o,
  input logic          sticky_unf_o,
  input logic          full_irq_o,
  input logic          ovf_evt,
  input logic          unf_evt
);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

  a_r1_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LVL_FULL);

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=>
      (ptr_o == $past(ptr_o) + 1'b1) && (top_o == $past(push_addr_i)));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> $stable(ptr_o) && sticky_ovf_o);

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(ptr_o) && sticky_unf_o);

  a_r6_swap_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=>
      $stable(ptr_o) && (top_o == $past(push_addr_i)));

  a_r8_evt_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt || unf_evt) |=> (sticky_ovf_o || sticky_unf_o));

  a_r8_full_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> sticky_full_o);

  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_irq_o |-> (sticky_full_o && !mask_full_i));

  a_r10_hwm_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwm_irq_o |-> (!full_o && !empty_o));

  a_r11_empty_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (top_o == '0));
endmodule

bind pc_ret_stack pc_ret_stack_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .push_addr_i   (push_addr_i),
  .mask_full_i   (mask_full_i),
  .top_o         (top_o),
  .ptr_o         (ptr_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .hwm_irq_o     (hwm_irq_o),
  .sticky_full_o (sticky_full_o),
  .sticky_ovf_o  (sticky_ovf_o),
  .sticky_unf_o  (sticky_unf_o),
  .full_irq_o    (full_irq_o),
  .ovf_evt       (ovf_evt),
  .unf_evt       (unf_evt)
);

// File: tb/pc_ret_stack_tb.sv
`timescale 1ns/1ps
module pc_ret_stack_tb;
  localparam int DEPTH = 30;
  localparam int AW    = 24;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, pop = 1'b0, mask = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] top;
  logic [CW-1:0] ptr;
  logic          full, empty, hwm, s_full, s_empty, s_ovf, s_unf, irq;

  int compared = 0;
  int mismatched = 0;

  // Reference model
  logic [AW-1:0] mq[$];
  bit m_sf, m_se, m_so, m_su;

  always #2.5 clk = ~clk;

  pc_ret_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
    .push_addr_i(addr), .mask_full_i(mask), .clr_sticky_i(clr),
    .top_o(top), .ptr_o(ptr), .full_o(full), .empty_o(empty),
    .hwm_irq_o(hwm), .sticky_full_o(s_full), .sticky_empty_o(s_empty),
    .sticky_ovf_o(s_ovf), .sticky_unf_o(s_unf), .full_irq_o(irq)
  );

  task automatic chk(string what, string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_top();
    return (mq.size() == 0) ? '0 : mq[mq.size() - 1];
  endfunction

  task automatic compare_all();
    chk("ptr",     "R2/R4", ptr, mq.size());
    chk("top",     "R6/R11", top, exp_top());
    chk("full",    "R7", full, mq.size() == DEPTH);
    chk("empty",   "R7", empty, mq.size() == 0);
    chk("hwm",     "R10", hwm, mq.size() == DEPTH - 1);
    chk("st_full", "R8", s_full, m_sf);
    chk("st_empty","R8", s_empty, m_se);
    chk("st_ovf",  "R3", s_ovf, m_so);
    chk("st_unf",  "R5", s_unf, m_su);
    chk("irq",     "R9", irq, m_sf && !mask);
  endtask

  // One clock: drive at the falling edge, model at the rising edge, sample after it.
  task automatic step(bit p, bit q, logic [AW-1:0] d, bit c, bit m);
    int pre;
    bit ev_o, ev_u;
    @(negedge clk);
    push = p; pop = q; addr = d; clr = c; mask = m;
    @(posedge clk);
    pre = mq.size();
    ev_o = 0; ev_u = 0;
    if (p && q) begin
      if (pre == 0) ev_u = 1; else mq[pre - 1] = d;
    end else if (p) begin
      if (pre == DEPTH) ev_o = 1; else mq.push_back(d);
    end else if (q) begin
      if (pre == 0) ev_u = 1; else void'(mq.pop_back());
    end
    m_sf = (c ? 1'b0 : m_sf) | (pre == DEPTH);
    m_se = (c ? 1'b0 : m_se) | (pre == 0);
    m_so = (c ? 1'b0 : m_so) | ev_o;
    m_su = (c ? 1'b0 : m_su) | ev_u;
    #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    #12;
    // R1: reset state
    chk("ptr_rst", "R1", ptr, 0);
    chk("empty_rst", "R1", empty, 1);
    chk("sticky_rst", "R1", {s_full, s_empty, s_ovf, s_unf, irq, hwm, full}, 0);
    chk("top_rst", "R11", top, 0);
    rst_n = 1'b1;

    // R5: pop on empty; R6: push and pop together on empty
    step(0, 1, 24'h0, 0, 0);
    step(1, 1, 24'hABCDEF, 0, 0);
    chk("swap_empty_ptr", "R6", ptr, 0);
    step(0, 0, 0, 1, 0);

    // R2 / R10: climb to high water, then the last push fills the stack
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, AW'(24'h100000 + i * 7), 0, 1);
      if (i == DEPTH - 2) chk("hwm_at_29", "R10", hwm, 1);
    end
    chk("full_at_30", "R7", full, 1);
    step(0, 0, 0, 0, 1);
    chk("irq_masked", "R9", irq, 0);
    step(0, 0, 0, 0, 0);
    chk("irq_unmasked", "R9", irq, 1);
    // R3: push on full is refused
    step(1, 0, 24'hDEAD00, 0, 0);
    chk("ovf_top_kept", "R3", top, 24'h100000 + (DEPTH - 1) * 7);
    // R6: replace while full
    step(1, 1, 24'h123456, 0, 0);
    chk("swap_full_top", "R6", top, 24'h123456);
    // R8: clear while still full keeps sticky full
    step(0, 0, 0, 1, 0);
    chk("clr_while_full", "R8", s_full, 1);
    // R4: drain in LIFO order
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 0);

    // Random phases; push-heavy phases reach the top of the stack
    for (int ph = 0; ph < 16; ph++) begin
      int bias;
      bias = (ph % 3 == 0) ? 85 : ((ph % 3 == 1) ? 20 : 50);
      for (int n = 0; n < 150; n++) begin
        int r;
        bit p, q;
        r = int'($urandom_range(99));
        p = (r < bias);
        q = (int'($urandom_range(99)) >= bias) || ($urandom_range(15) == 0);
        step(p, q, AW'($urandom), $urandom_range(19) == 0, $urandom_range(3) == 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule